// File: doc/BRIEF.md
# Receive Clock-Recovery Phase Tracker

This block recovers bit-cell timing from a serial receive line that carries no clock of its own. In its oversampling modes it counts sixteen ticks of a chosen reference per nominal bit cell and nudges that count whenever a line transition lands off its expected place. The expected place depends on the line coding. For NRZ and NRZI it is the cell boundary (phase 0). For Manchester it is the middle of the cell (phase 8). From the tracked phase it issues a data sample strobe and a mid-cell strobe. A lock flag reports whether transitions keep arriving where they should.

The tick reference is one of several prescaled internal tick trains or an external receive-clock tick. When the external tick is picked and the one-times flag is set, each external tick already marks one bit. In that case no phase tracking is done and the strobes simply follow the external tick. Data decoding and the generation of the prescaled ticks happen elsewhere.

The control state machine has four states: `ST_OFF` (tracking disabled, all outputs low), `ST_HUNT` (tracking, not yet locked), `ST_LOCK` (tracking and locked) and `ST_BYPASS` (one-times external clock). Its transitions are:
- OFF→HUNT: enable with bypass not requested.
- OFF→BYPASS: enable with bypass requested.
- HUNT→LOCK: the eighth consecutive accounting cell with an in-window transition.
- LOCK→HUNT: the fourth consecutive accounting cell with no counted transition.
- HUNT/LOCK→BYPASS: bypass is requested.
- BYPASS→HUNT: bypass is withdrawn.
- Any state→OFF: enable drops.

Top module: `rx_clock_recovery`

## Requirements
- R1: While `enable` is low, `sample_stb`, `mid_stb` and `locked` are low from the next clock cycle on, whatever the line and ticks do.
- R2: `src_sel` values 0..NSRC-1 pick bit `src_sel` of `int_tick`; the value NSRC picks `ext_tick`; a picked source that never ticks yields no strobes.
- R3: Outside bypass the phase counter advances only on picked ticks, and a nominal cell is 16 ticks. With NRZ and ticks every other clock, exactly one sample strobe appears per 32-clock cell once locked.
- R4: Strobes fall where the phase reaches a threshold: NRZ/NRZI sample and mid at phase 8; Manchester mid at phase 8 and sample at phase 12. With a tick every clock and a locked loop, the sample strobe is visible 8 clocks after the line changes in NRZ and 4 in Manchester. The mid strobe is visible 8 clocks after the change in NRZ and in the same clock as the change in Manchester.
- R5: A transition seen at deviation d = phase − expected phase (mod 16) of 1..7 holds the counter for one tick (cell one longer). A deviation of 9..15 skips one count (cell one shorter). A deviation of 0 or 8 changes nothing. At most one such correction is made per counter wrap. After a single one-clock early or late shift the sample offset is back at 8 for NRZ; after a two-clock late shift it is 7, then 8 on the next cell.
- R6: The expected phase is 0 for NRZ/NRZI (`manch_mode`=0) and 8 for Manchester (`manch_mode`=1).
- R7: Lock accounting runs in cells centred on the expected phase. `locked` rises only from HUNT, after 8 consecutive accounting cells each holding a transition within ±2 ticks of the expected phase. It is low for the first 4 cells after enabling.
- R8: Once locked, `locked` stays high through 3 cells without transitions and falls after 4 consecutive cells without a counted transition.
- R9: With `ext_x1`=1 and `src_sel`=NSRC, `sample_stb` and `mid_stb` each pulse one clock after every `ext_tick` pulse, and `locked` is high.
- R10: In Manchester mode, extra transitions at cell boundaries (deviation 8) neither move the phase nor break lock.
- R11: During and directly after reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Turns recovery on |
| manch_mode | input | 1 | 1 = Manchester, 0 = NRZ/NRZI |
| ext_x1 | input | 1 | One-times external clock request |
| src_sel | input | SELW | Tick source select, NSRC = external |
| int_tick | input | NSRC | Prescaled internal tick strobes |
| ext_tick | input | 1 | External receive-clock tick strobe |
| rx_line | input | 1 | Synchronised receive line |
| sample_stb | output | 1 | Data sample strobe |
| mid_stb | output | 1 | Mid-cell strobe |
| locked | output | 1 | Recovered timing is locked |

## Verification
Both strobes are registered, so they appear one clock after the tick that carries the phase across its threshold. With a tick every clock, this places the sample strobe 8 (NRZ) or 4 (Manchester) clocks after a line change, and the Manchester mid strobe in the change's own clock. The bench changes the line just after a rising edge and counts falling edges from that clock, so each offset is compared with its fixed value. Bypass strobes are checked one clock after each external tick. The checks for lock and lock loss sit well clear of the accounting-cell edges: before the fifth cell for acquisition, and at the third and sixth silent cell for loss.

// File: rtl/rx_dpll_pkg.sv
package rx_dpll_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_HUNT   = 2'd1,
        ST_LOCK   = 2'd2,
        ST_BYPASS = 2'd3
    } dpll_state_t;
endpackage

// File: rtl/dpll_tick_sel.sv
module dpll_tick_sel #(
    parameter int NSRC = 3,
    parameter int SELW = 2
) (
    input  logic [NSRC-1:0] int_tick,
    input  logic            ext_tick,
    input  logic [SELW-1:0] sel,
    output logic            tick
);
    localparam int NALL = NSRC + 1;

    logic [NALL-1:0] all_ticks;

    assign all_ticks = {ext_tick, int_tick};

    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < NALL; i++) begin
            if (sel == SELW'(i)) tick = all_ticks[i];
        end
    end
endmodule

// File: rtl/dpll_phase.sv
module dpll_phase #(
    parameter int PH_W = 4,
    parameter int WIN  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic line,
    input  logic manch,
    output logic cross_mid,
    output logic cross_smp,
    output logic acct,
    output logic acct_good,
    output logic acct_edge
);
    localparam int CELL = 1 << PH_W;
    localparam int HALF = CELL / 2;
    localparam int QTR3 = (3 * CELL) / 4;

    logic [PH_W-1:0] phase, exp_ph, dev;
    logic [PH_W:0]   nxt;
    logic [1:0]      step;
    logic line_q, corr_used, has_good, has_edge;
    logic edge_now, late, early, in_win, counted, corr_applied;
    logic cross_q3, cross_wrap;

    assign exp_ph   = manch ? PH_W'(HALF) : '0;
    assign dev      = phase - exp_ph;
    assign edge_now = run && tick && (line != line_q);
    assign late     = edge_now && !dev[PH_W-1] && (dev != '0);
    assign early    = edge_now && dev[PH_W-1] && (dev != PH_W'(HALF));
    assign in_win   = (dev <= PH_W'(WIN)) || (dev >= PH_W'(CELL - WIN));
    assign counted  = edge_now && (dev != PH_W'(HALF));
    assign corr_applied = (late || early) && !corr_used;

    always_comb begin
        if (!tick)                    step = 2'd0;
        else if (late && !corr_used)  step = 2'd0;
        else if (early && !corr_used) step = 2'd2;
        else                          step = 2'd1;
    end

    assign nxt        = {1'b0, phase} + (PH_W+1)'(step);
    assign cross_mid  = run && tick && ({1'b0, phase} < (PH_W+1)'(HALF)) && (nxt >= (PH_W+1)'(HALF));
    assign cross_q3   = run && tick && ({1'b0, phase} < (PH_W+1)'(QTR3)) && (nxt >= (PH_W+1)'(QTR3));
    assign cross_wrap = run && tick && nxt[PH_W];
    assign cross_smp  = manch ? cross_q3 : cross_mid;
    assign acct       = manch ? cross_wrap : cross_mid;
    assign acct_good  = has_good || (edge_now && in_win);
    assign acct_edge  = has_edge || counted;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase     <= '0;
            line_q    <= 1'b0;
            corr_used <= 1'b0;
            has_good  <= 1'b0;
            has_edge  <= 1'b0;
        end else begin
            if (tick) line_q <= line;
            if (!run) begin
                phase     <= '0;
                corr_used <= 1'b0;
                has_good  <= 1'b0;
                has_edge  <= 1'b0;
            end else begin
                phase <= nxt[PH_W-1:0];
                if (cross_wrap)        corr_used <= 1'b0;
                else if (corr_applied) corr_used <= 1'b1;
                if (acct) begin
                    has_good <= 1'b0;
                    has_edge <= 1'b0;
                end else begin
                    has_good <= acct_good;
                    has_edge <= acct_edge;
                end
            end
        end
    end

    // R5: a tracked tick moves the phase by 0, 1 or 2 counts only
    p_step_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick) |=> (PH_W'(phase - $past(phase)) <= PH_W'(2)));

    // R3: without a tick the phase does not move
    p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(phase));
endmodule

// File: rtl/dpll_lock_fsm.sv
module dpll_lock_fsm
    import rx_dpll_pkg::*;
#(
    parameter int LOCK_CELLS = 8,
    parameter int LOSS_CELLS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bypass,
    input  logic tick,
    input  logic cross_smp,
    input  logic cross_mid,
    input  logic acct,
    input  logic acct_good,
    input  logic acct_edge,
    output logic run,
    output logic sample_stb,
    output logic mid_stb,
    output logic locked
);
    localparam int GW = $clog2(LOCK_CELLS + 1);
    localparam int MW = $clog2(LOSS_CELLS + 1);

    dpll_state_t   state_q, state_d;
    logic [GW-1:0] good_cnt;
    logic [MW-1:0] miss_cnt;
    logic          gain, loss, track_d;

    assign run     = (state_q == ST_HUNT) || (state_q == ST_LOCK);
    assign track_d = (state_d == ST_HUNT) || (state_d == ST_LOCK);
    assign gain    = acct && acct_good && (good_cnt == GW'(LOCK_CELLS - 1));
    assign loss    = acct && !acct_edge && (miss_cnt == MW'(LOSS_CELLS - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:    if (enable) state_d = bypass ? ST_BYPASS : ST_HUNT;
            ST_HUNT:   if (!enable) state_d = ST_OFF;
                       else if (bypass) state_d = ST_BYPASS;
                       else if (gain) state_d = ST_LOCK;
            ST_LOCK:   if (!enable) state_d = ST_OFF;
                       else if (bypass) state_d = ST_BYPASS;
                       else if (loss) state_d = ST_HUNT;
            ST_BYPASS: if (!enable) state_d = ST_OFF;
                       else if (!bypass) state_d = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            good_cnt <= '0;
            miss_cnt <= '0;
        end else if (!run || (state_d != state_q)) begin
            good_cnt <= '0;
            miss_cnt <= '0;
        end else if (acct) begin
            good_cnt <= acct_good ? ((good_cnt == GW'(LOCK_CELLS)) ? good_cnt : good_cnt + 1'b1) : '0;
            miss_cnt <= acct_edge ? '0 : ((miss_cnt == MW'(LOSS_CELLS)) ? miss_cnt : miss_cnt + 1'b1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_stb <= 1'b0;
            mid_stb    <= 1'b0;
            locked     <= 1'b0;
        end else begin
            sample_stb <= (state_d == ST_BYPASS) ? tick : (track_d && cross_smp);
            mid_stb    <= (state_d == ST_BYPASS) ? tick : (track_d && cross_mid);
            locked     <= (state_d == ST_LOCK) || (state_d == ST_BYPASS);
        end
    end

    // R1: disabling silences every output from the next cycle
    p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sample_stb && !mid_stb && !locked));

    // R4: tracked sample strobes never come in back-to-back cycles
    p_strobe_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && state_q != ST_BYPASS) |=> (!sample_stb || state_q == ST_BYPASS));

    // R7: lock is only won from hunting, on a good accounting cell
    p_lock_from_hunt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(locked) && state_q != ST_BYPASS) |-> ($past(state_q) == ST_HUNT && $past(acct && acct_good)));
endmodule

// File: rtl/rx_clock_recovery.sv
module rx_clock_recovery #(
    parameter int NSRC       = 3,
    parameter int SELW       = $clog2(NSRC + 1),
    parameter int PH_W       = 4,
    parameter int WIN        = 2,
    parameter int LOCK_CELLS = 8,
    parameter int LOSS_CELLS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            manch_mode,
    input  logic            ext_x1,
    input  logic [SELW-1:0] src_sel,
    input  logic [NSRC-1:0] int_tick,
    input  logic            ext_tick,
    input  logic            rx_line,
    output logic            sample_stb,
    output logic            mid_stb,
    output logic            locked
);
    logic tick, run, bypass;
    logic cross_mid, cross_smp, acct, acct_good, acct_edge;

    assign bypass = ext_x1 && (src_sel == SELW'(NSRC));

    dpll_tick_sel #(.NSRC(NSRC), .SELW(SELW)) u_sel (
        .int_tick (int_tick),
        .ext_tick (ext_tick),
        .sel      (src_sel),
        .tick     (tick)
    );

    dpll_phase #(.PH_W(PH_W), .WIN(WIN)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .tick      (tick),
        .line      (rx_line),
        .manch     (manch_mode),
        .cross_mid (cross_mid),
        .cross_smp (cross_smp),
        .acct      (acct),
        .acct_good (acct_good),
        .acct_edge (acct_edge)
    );

    dpll_lock_fsm #(.LOCK_CELLS(LOCK_CELLS), .LOSS_CELLS(LOSS_CELLS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .bypass     (bypass),
        .tick       (tick),
        .cross_smp  (cross_smp),
        .cross_mid  (cross_mid),
        .acct       (acct),
        .acct_good  (acct_good),
        .acct_edge  (acct_edge),
        .run        (run),
        .sample_stb (sample_stb),
        .mid_stb    (mid_stb),
        .locked     (locked)
    );
endmodule

// File: tb/test_rx_clock_recovery.sv
`timescale 1ns/1ps
module test_rx_clock_recovery;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       manch = 1'b0;
    logic       ext_x1 = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic [2:0] int_tick;
    logic       ext_tick = 1'b0;
    logic       line = 1'b0;
    logic       sample_stb, mid_stb, locked;
    logic       tick_half = 1'b0;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    assign int_tick = {1'b0, tick_half, 1'b1};

    always #4 clk = ~clk;

    rx_clock_recovery i_rx_clock_recovery (
        .clk(clk), .rst_n(rst_n), .enable(enable), .manch_mode(manch),
        .ext_x1(ext_x1), .src_sel(src_sel), .int_tick(int_tick),
        .ext_tick(ext_tick), .rx_line(line), .sample_stb(sample_stb),
        .mid_stb(mid_stb), .locked(locked)
    );

    initial forever begin
        @(posedge clk); #1 tick_half = ~tick_half;
    end

    initial forever begin
        repeat (4) begin @(posedge clk); #1 ext_tick = 1'b0; end
        @(posedge clk); #1 ext_tick = 1'b1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Entered just after a rising edge; toggles the line at its start when asked.
    task automatic run_cell(input int len, input bit tog, input int extra,
                            output int so, output int mo, output int ns);
        if (tog) line = ~line;
        so = -1; mo = -1; ns = 0;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            if (sample_stb) begin ns++; if (so < 0) so = k; end
            if (mid_stb && mo < 0) mo = k;
            @(posedge clk); #1;
            if (extra > 0 && k + 1 == extra) line = ~line;
        end
    endtask

    task automatic cells(input int n, input int len);
        int so, mo, ns;
        for (int i = 0; i < n; i++) run_cell(len, 1'b1, 0, so, mo, ns);
    endtask

    task automatic restart(input bit m, input logic [1:0] s, input bit x1);
        enable = 1'b0;
        repeat (3) begin @(posedge clk); #1; end
        @(negedge clk);
        chk("R1 locked after disable", int'(locked), 0);
        @(posedge clk); #1;
        manch = m; src_sel = s; ext_x1 = x1; enable = 1'b1;
        repeat (3) begin @(posedge clk); #1; end
    endtask

    initial begin
        int so, mo, ns, sum, mism;
        logic prev_ext;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R11 reset sample_stb", int'(sample_stb), 0);
        chk("R11 reset mid_stb", int'(mid_stb), 0);
        chk("R11 reset locked", int'(locked), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: disabled block ignores line activity
        sum = 0;
        for (int i = 0; i < 4; i++) begin run_cell(16, 1'b1, 0, so, mo, ns); sum += ns; end
        chk("R1 strobes while disabled", sum, 0);
        chk("R1 locked while disabled", int'(locked), 0);

        // NRZ, tick every clock
        restart(1'b0, 2'd0, 1'b0);
        cells(4, 16);
        chk("R7 no lock after 4 cells", int'(locked), 0);
        cells(26, 16);
        chk("R7 locked NRZ", int'(locked), 1);
        run_cell(16, 1'b1, 0, so, mo, ns);
        chk("R4 NRZ sample offset", so, 8);
        chk("R6 NRZ mid offset", mo, 8);

        // R5: corrections
        run_cell(17, 1'b1, 0, so, mo, ns);
        run_cell(16, 1'b1, 0, so, mo, ns);
        chk("R5 late by one offset", so, 8);
        run_cell(18, 1'b1, 0, so, mo, ns);
        run_cell(16, 1'b1, 0, so, mo, ns);
        chk("R5 late by two offset", so, 7);
        run_cell(16, 1'b1, 0, so, mo, ns);
        chk("R5 late by two recovers", so, 8);
        run_cell(15, 1'b1, 0, so, mo, ns);
        run_cell(16, 1'b1, 0, so, mo, ns);
        chk("R5 early by one offset", so, 8);
        chk("R5 lock kept through shifts", int'(locked), 1);

        // R8: loss of lock
        for (int i = 0; i < 2; i++) run_cell(16, 1'b0, 0, so, mo, ns);
        chk("R8 lock held after 2 silent cells", int'(locked), 1);
        for (int i = 0; i < 4; i++) run_cell(16, 1'b0, 0, so, mo, ns);
        chk("R8 lock lost after 6 silent cells", int'(locked), 0);

        // Manchester
        restart(1'b1, 2'd0, 1'b0);
        cells(30, 16);
        chk("R7 locked Manchester", int'(locked), 1);
        run_cell(16, 1'b1, 0, so, mo, ns);
        chk("R4 Manchester sample offset", so, 4);
        chk("R6 Manchester mid offset", mo, 0);

        // R10: boundary transitions at deviation 8
        for (int i = 0; i < 4; i++) begin
            run_cell(16, 1'b1, 8, so, mo, ns);
            chk("R10 sample offset with boundary edges", so, 4);
        end
        run_cell(16, 1'b1, 0, so, mo, ns);
        chk("R10 no drift after boundary edges", so, 4);
        chk("R10 lock kept", int'(locked), 1);

        // R2/R3: half-rate tick source
        restart(1'b0, 2'd1, 1'b0);
        cells(30, 32);
        chk("R3 locked on half-rate ticks", int'(locked), 1);
        for (int i = 0; i < 3; i++) begin
            run_cell(32, 1'b1, 0, so, mo, ns);
            chk("R3 one sample strobe per 32 clocks", ns, 1);
        end

        // R2: idle tick source
        restart(1'b0, 2'd2, 1'b0);
        sum = 0;
        for (int i = 0; i < 6; i++) begin run_cell(16, 1'b1, 0, so, mo, ns); sum += ns; end
        chk("R2 no strobes from idle source", sum, 0);
        chk("R2 no lock from idle source", int'(locked), 0);

        // R9: one-times external clock
        restart(1'b0, 2'd3, 1'b1);
        @(negedge clk);
        prev_ext = ext_tick;
        sum = 0; mism = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (sample_stb !== prev_ext || mid_stb !== prev_ext) mism++;
            if (sample_stb) sum++;
            prev_ext = ext_tick;
        end
        chk("R9 strobes follow external tick", mism, 0);
        chk("R9 strobe count", sum, 20);
        chk("R9 locked in bypass", int'(locked), 1);

        enable = 1'b0;
        @(posedge clk); #1;
        @(negedge clk);
        chk("R1 outputs low after disable", int'(sample_stb | mid_stb | locked), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule